// File: doc/BRIEF.md
# Bitwise Programmable Truth-Table Unit

This block evaluates a small truth table separately at every bit position of a word. The three-input form takes its eight-entry table from an immediate byte. It combines one bit from each of two sources with the matching bit of the current destination value, so the destination also acts as a source. The two-input form takes a four-entry table from one nibble of the low byte of a table register. It combines the two sources bit by bit and ignores the destination.

Two field forms apply the same lookups to the lowest FIELD_W bits only. In these forms a per-bit write mask decides which result bits are replaced. A bit whose mask is clear keeps its old destination value, and all bits above the field read as zero. When the caller asks for it, a zero flag reports an all-zero result. The logic has no state; a parameter adds one register stage on the output.

Top module: `bitlut_unit`

## Requirements
- R1: With mode_i = 2'b00, result bit i equals table_imm_i[{dst_i[i], src1_i[i], src2_i[i]}], where dst_i gives index bit 2 and src2_i gives index bit 0.
- R2: With mode_i = 2'b01, the table is tbl_byte_i[3:0] when nib_hi_i = 0 and tbl_byte_i[7:4] when nib_hi_i = 1. Result bit i equals that table at index {src1_i[i], src2_i[i]}, with src1_i giving index bit 1.
- R3: With mode_i = 2'b01, neither dst_i nor the unselected nibble of tbl_byte_i changes the result.
- R4: With mode_i = 2'b10, each unmasked field bit k (k < FIELD_W) follows the R1 lookup on bit k.
- R5: With mode_i = 2'b11, each unmasked field bit k equals fld_tbl_i[{src1_i[k], src2_i[k]}].
- R6: In both field modes (mode_i[1] = 1), a field bit k with mask_i[k] = 0 equals dst_i[k].
- R7: In both field modes, result bits FIELD_W and above are zero, whatever the upper source bits are.
- R8: zero_o is 1 exactly when rec_i = 1 and the whole result is zero. With rec_i = 0, zero_o is 0.
- R9: Results appear OUT_STAGES cycles after the inputs (default 1). While rst_n is low, res_o and zero_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 00 word 3-input, 01 word 2-input, 10 field 3-input, 11 field 2-input |
| src1_i | input | DATA_W | First source operand |
| src2_i | input | DATA_W | Second source operand |
| dst_i | input | DATA_W | Current destination value |
| table_imm_i | input | 8 | Immediate table for the 3-input modes |
| tbl_byte_i | input | 8 | Low byte of the table register for mode 01 |
| nib_hi_i | input | 1 | Selects the high nibble of tbl_byte_i |
| fld_tbl_i | input | FIELD_W | Field-sized table for mode 11 |
| mask_i | input | FIELD_W | Per-bit write mask for the field modes |
| rec_i | input | 1 | Enables the zero flag |
| res_o | output | DATA_W | Result word |
| zero_o | output | 1 | Result-is-zero flag |

## Verification
With the default single output stage, the result word and the zero flag both settle one rising edge after their inputs; they share one register and so have the same latency. The bench changes inputs on a falling edge, lets one rising edge pass, and samples on the next falling edge, before any newer input can reach the outputs. The checker keeps its own copy of the inputs, delayed by the same OUT_STAGES, so it compares every output with the inputs that produced it.

// File: rtl/bitlut_pkg.sv
package bitlut_pkg;
   typedef enum logic [1:0] {
      LM_WORD_TRI = 2'b00,
      LM_WORD_BIN = 2'b01,
      LM_FLD_TRI  = 2'b10,
      LM_FLD_BIN  = 2'b11
   } lut_mode_e;

   localparam int TBL_W = 8;
   localparam int NIB_W = 4;
endpackage

// File: rtl/bitlut_tblsel.sv
module bitlut_tblsel
   import bitlut_pkg::*;
#(
   parameter int FIELD_W = 4
) (
   input  lut_mode_e           mode_i,
   input  logic [TBL_W-1:0]    imm_i,
   input  logic [TBL_W-1:0]    byte_i,
   input  logic                nib_hi_i,
   input  logic [FIELD_W-1:0]  fld_tbl_i,
   output logic [TBL_W-1:0]    tbl_o
);
   logic [NIB_W-1:0] nib;

   always_comb begin
      nib = nib_hi_i ? byte_i[2*NIB_W-1:NIB_W] : byte_i[NIB_W-1:0];
      unique case (mode_i)
         LM_WORD_TRI,
         LM_FLD_TRI:  tbl_o = imm_i;
         LM_WORD_BIN: tbl_o = {nib, nib};
         LM_FLD_BIN:  tbl_o = {fld_tbl_i[NIB_W-1:0], fld_tbl_i[NIB_W-1:0]};
         default:     tbl_o = imm_i;
      endcase
   end
endmodule

// File: rtl/bitlut_lanes.sv
module bitlut_lanes
   import bitlut_pkg::*;
#(
   parameter int W = 64
) (
   input  logic [TBL_W-1:0] tbl_i,
   input  logic [W-1:0]     lo_i,
   input  logic [W-1:0]     mid_i,
   input  logic [W-1:0]     hi_i,
   output logic [W-1:0]     y_o
);
   for (genvar k = 0; k < W; k++) begin : g_lane
      logic [2:0] idx;
      assign idx    = {hi_i[k], mid_i[k], lo_i[k]};
      assign y_o[k] = tbl_i[idx];
   end
endmodule

// File: rtl/bitlut_fieldmerge.sv
module bitlut_fieldmerge #(
   parameter int DATA_W  = 64,
   parameter int FIELD_W = 4
) (
   input  logic               fld_en_i,
   input  logic [FIELD_W-1:0] mask_i,
   input  logic [FIELD_W-1:0] dst_i,
   input  logic [DATA_W-1:0]  lut_i,
   output logic [DATA_W-1:0]  y_o
);
   for (genvar k = 0; k < FIELD_W; k++) begin : g_fld
      assign y_o[k] = (fld_en_i && !mask_i[k]) ? dst_i[k] : lut_i[k];
   end
   if (DATA_W > FIELD_W) begin : g_upper
      assign y_o[DATA_W-1:FIELD_W] = fld_en_i ? '0 : lut_i[DATA_W-1:FIELD_W];
   end
endmodule

// File: rtl/bitlut_unit.sv
module bitlut_unit
   import bitlut_pkg::*;
#(
   parameter int DATA_W     = 64,
   parameter int FIELD_W    = 4,
   parameter int OUT_STAGES = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         mode_i,
   input  logic [DATA_W-1:0]  src1_i,
   input  logic [DATA_W-1:0]  src2_i,
   input  logic [DATA_W-1:0]  dst_i,
   input  logic [7:0]         table_imm_i,
   input  logic [7:0]         tbl_byte_i,
   input  logic               nib_hi_i,
   input  logic [FIELD_W-1:0] fld_tbl_i,
   input  logic [FIELD_W-1:0] mask_i,
   input  logic               rec_i,
   output logic [DATA_W-1:0]  res_o,
   output logic               zero_o
);
   initial begin
      assert (FIELD_W == NIB_W)
         else $error("FIELD_W must equal %0d", NIB_W);
      assert (DATA_W >= FIELD_W)
         else $error("DATA_W must be at least FIELD_W");
      assert (OUT_STAGES == 0 || OUT_STAGES == 1)
         else $error("OUT_STAGES must be 0 or 1");
   end

   lut_mode_e          mode;
   logic [TBL_W-1:0]   tbl;
   logic [DATA_W-1:0]  lut_y;
   logic [DATA_W-1:0]  res_c;
   logic               zero_c;

   assign mode = lut_mode_e'(mode_i);

   bitlut_tblsel #(.FIELD_W(FIELD_W)) u_tbl (
      .mode_i    (mode),
      .imm_i     (table_imm_i),
      .byte_i    (tbl_byte_i),
      .nib_hi_i  (nib_hi_i),
      .fld_tbl_i (fld_tbl_i),
      .tbl_o     (tbl)
   );

   bitlut_lanes #(.W(DATA_W)) u_lanes (
      .tbl_i (tbl),
      .lo_i  (src2_i),
      .mid_i (src1_i),
      .hi_i  (dst_i),
      .y_o   (lut_y)
   );

   bitlut_fieldmerge #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_merge (
      .fld_en_i (mode_i[1]),
      .mask_i   (mask_i),
      .dst_i    (dst_i[FIELD_W-1:0]),
      .lut_i    (lut_y),
      .y_o      (res_c)
   );

   assign zero_c = rec_i && (res_c == '0);

   if (OUT_STAGES == 0) begin : g_comb
      assign res_o  = res_c;
      assign zero_o = zero_c;
   end else begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_o  <= '0;
            zero_o <= 1'b0;
         end else begin
            res_o  <= res_c;
            zero_o <= zero_c;
         end
      end
   end
endmodule

// File: rtl/bitlut_chk.sv
module bitlut_chk #(
   parameter int DATA_W     = 64,
   parameter int FIELD_W    = 4,
   parameter int OUT_STAGES = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         mode_i,
   input logic [DATA_W-1:0]  src1_i,
   input logic [DATA_W-1:0]  dst_i,
   input logic [7:0]         table_imm_i,
   input logic [7:0]         tbl_byte_i,
   input logic               nib_hi_i,
   input logic [FIELD_W-1:0] mask_i,
   input logic               rec_i,
   input logic [DATA_W-1:0]  res_o,
   input logic               zero_o
);
   logic [1:0]         p_mode;
   logic [DATA_W-1:0]  p_src1, p_dst;
   logic [7:0]         p_imm;
   logic [3:0]         p_nib;
   logic [FIELD_W-1:0] p_mask;
   logic               p_rec;
   logic [3:0]         nib_now;

   assign nib_now = nib_hi_i ? tbl_byte_i[7:4] : tbl_byte_i[3:0];

   if (OUT_STAGES == 0) begin : g_now
      assign p_mode = mode_i;
      assign p_src1 = src1_i;
      assign p_dst  = dst_i;
      assign p_imm  = table_imm_i;
      assign p_nib  = nib_now;
      assign p_mask = mask_i;
      assign p_rec  = rec_i;
   end else begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            p_mode <= '0; p_src1 <= '0; p_dst <= '0; p_imm <= '0;
            p_nib  <= '0; p_mask <= '0; p_rec <= 1'b0;
         end else begin
            p_mode <= mode_i; p_src1 <= src1_i; p_dst <= dst_i;
            p_imm  <= table_imm_i; p_nib <= nib_now;
            p_mask <= mask_i; p_rec <= rec_i;
         end
      end
   end

   assert_tri_dst_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (p_mode == 2'b00 && p_imm == 8'hF0) |-> (res_o == p_dst));

   assert_bin_src1_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (p_mode == 2'b01 && p_nib == 4'hC) |-> (res_o == p_src1));

   assert_mask_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      p_mode[1] |-> (((res_o[FIELD_W-1:0] ^ p_dst[FIELD_W-1:0]) & ~p_mask) == '0));

   assert_field_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      p_mode[1] |-> ((res_o >> FIELD_W) == '0));

   assert_zero_flag_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
      zero_o |-> (res_o == '0));

   assert_zero_needs_rec_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !p_rec |-> !zero_o);
endmodule

bind bitlut_unit bitlut_chk #(
   .DATA_W(DATA_W), .FIELD_W(FIELD_W), .OUT_STAGES(OUT_STAGES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .src1_i(src1_i), .dst_i(dst_i),
   .table_imm_i(table_imm_i), .tbl_byte_i(tbl_byte_i), .nib_hi_i(nib_hi_i),
   .mask_i(mask_i), .rec_i(rec_i), .res_o(res_o), .zero_o(zero_o)
);

// File: tb/sim_bitlut_unit.sv
module sim_bitlut_unit;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 64;
   localparam int FW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode_i = '0;
   logic [DW-1:0] src1_i = '0, src2_i = '0, dst_i = '0;
   logic [7:0]    table_imm_i = '0, tbl_byte_i = '0;
   logic          nib_hi_i = 1'b0;
   logic [FW-1:0] fld_tbl_i = '0, mask_i = '0;
   logic          rec_i = 1'b0;
   logic [DW-1:0] res_o;
   logic          zero_o;

   int total = 0;
   int bad = 0;
   bit done = 0;
   logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

   always #(CLK_PERIOD/2) clk = ~clk;

   bitlut_unit #(.DATA_W(DW), .FIELD_W(FW), .OUT_STAGES(1)) u0 (.*);

   function automatic logic [63:0] nextr();
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 7);
      rng = rng ^ (rng << 17);
      return rng;
   endfunction

   function automatic logic [DW-1:0] model(input logic [1:0] m,
      input logic [DW-1:0] s1, s2, d, input logic [7:0] imm, byt,
      input logic nh, input logic [FW-1:0] ft, mk);
      logic [DW-1:0] r;
      logic [3:0] nib;
      nib = nh ? byt[7:4] : byt[3:0];
      for (int i = 0; i < DW; i++) begin
         if (m[1] && i >= FW) r[i] = 1'b0;
         else if (m[1] && !mk[i]) r[i] = d[i];
         else case (m)
            2'b00, 2'b10: r[i] = imm[{d[i], s1[i], s2[i]}];
            2'b01:        r[i] = nib[{s1[i], s2[i]}];
            default:      r[i] = ft[{s1[i], s2[i]}];
         endcase
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [DW-1:0] act, exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply(input string req, input logic [1:0] m,
      input logic [DW-1:0] s1, s2, d, input logic [7:0] imm, byt,
      input logic nh, input logic [FW-1:0] ft, mk, input logic rc);
      logic [DW-1:0] e;
      @(negedge clk);
      mode_i = m; src1_i = s1; src2_i = s2; dst_i = d; table_imm_i = imm;
      tbl_byte_i = byt; nib_hi_i = nh; fld_tbl_i = ft; mask_i = mk; rec_i = rc;
      e = model(m, s1, s2, d, imm, byt, nh, ft, mk);
      @(posedge clk);
      @(negedge clk);
      check(req, res_o, e);
      check({req, "/R8"}, {63'd0, zero_o}, {63'd0, rc && (e == '0)});
   endtask

   task automatic t_reset();
      // R9: outputs are cleared while reset is held
      check("R9 reset res", res_o, '0);
      check("R9 reset zero", {63'd0, zero_o}, '0);
   endtask

   task automatic t_word_tri();
      logic [7:0] tbls [4] = '{8'hCA, 8'h96, 8'hE8, 8'hF0};
      foreach (tbls[j]) begin
         apply("R1", 2'b00, nextr(), nextr(), nextr(), tbls[j], nextr(), 1'b0, '0, '0, 1'b0);
      end
      apply("R1 all-ones table", 2'b00, nextr(), nextr(), nextr(), 8'hFF, 8'h00, 1'b0, '0, '0, 1'b1);
   endtask

   task automatic t_word_bin();
      logic [63:0] a, b;
      a = nextr(); b = nextr();
      apply("R2 low nibble", 2'b01, a, b, nextr(), 8'h00, 8'h36, 1'b0, '0, '0, 1'b0);
      apply("R2 high nibble", 2'b01, a, b, nextr(), 8'h00, 8'h36, 1'b1, '0, '0, 1'b0);
      // R3: different dst and a changed unselected nibble: result must match a fixed expectation
      apply("R3 dst ignored", 2'b01, a, b, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 8'h86, 1'b0, '0, '0, 1'b0);
      apply("R3 other nibble ignored", 2'b01, a, b, 64'h0, 8'h00, 8'hF6, 1'b0, '0, '0, 1'b0);
      apply("R2 nibble C passes src1", 2'b01, a, b, 64'h0, 8'h00, 8'hC0, 1'b1, '0, '0, 1'b0);
   endtask

   task automatic t_field();
      apply("R4", 2'b10, nextr(), nextr(), nextr(), 8'h96, 8'h00, 1'b0, '0, 4'hF, 1'b0);
      apply("R5", 2'b11, nextr(), nextr(), nextr(), 8'h00, 8'h00, 1'b0, 4'h6, 4'hF, 1'b0);
      apply("R6 mask none", 2'b11, nextr(), nextr(), 64'h5, 8'h00, 8'h00, 1'b0, 4'hF, 4'h0, 1'b0);
      apply("R6 mask part", 2'b10, nextr(), nextr(), nextr(), 8'hFF, 8'h00, 1'b0, '0, 4'h9, 1'b0);
      // R7: upper source bits all ones, upper result must stay zero
      apply("R7 upper zero", 2'b10, {DW{1'b1}}, {DW{1'b1}}, {DW{1'b1}}, 8'hFF, 8'h00, 1'b0, '0, 4'hF, 1'b1);
   endtask

   task automatic t_zero();
      apply("R8 rec on zero", 2'b00, nextr(), nextr(), nextr(), 8'h00, 8'h00, 1'b0, '0, '0, 1'b1);
      apply("R8 rec off zero", 2'b00, nextr(), nextr(), nextr(), 8'h00, 8'h00, 1'b0, '0, '0, 1'b0);
      apply("R8 rec on nonzero", 2'b11, 64'h0, 64'h0, 64'h0, 8'h00, 8'h00, 1'b0, 4'h1, 4'h1, 1'b1);
      apply("R8 field all zero", 2'b11, 64'h0, 64'h0, 64'hFFF0, 8'h00, 8'h00, 1'b0, 4'hE, 4'hF, 1'b1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_word_tri();
      t_word_bin();
      t_field();
      t_zero();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule